// File: doc/BRIEF.md
# Stereo Audio Serial Data Receiver

This block turns a two-channel serial PCM stream into parallel sample pairs. It is clocked directly by the audio bit clock and samples the frame clock and the data line on each rising edge. Each frame carries one left and one right word, sent most significant bit first. When the right word of a frame is complete, the block presents both words as signed 24-bit values, together with a strobe that is high for one cycle.

Three static configuration inputs control reception. One selects the framing: right-justified, where the word ends on the last bit before the frame-clock change, or I2S, where the word starts one bit after that change. One selects the word length. One selects which frame-clock level means the left channel. A right-justified frame that is exactly 32 bit clocks long is always read as 16-bit data. A frame that is too short for the selected word length is reported on its own strobe, and the previous sample pair is kept. Configuration is meant to change only while the block is held in reset.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `valid_o` and `short_o` are 0 and `left_o` and `right_o` are all zeros.
- R2: With `fmt_i2s_i`=0 (right-justified), a channel word is the last N bits sampled before the frame-clock change, MSB first. Any earlier bits in that half-frame are ignored.
- R3: With `fmt_i2s_i`=1 (I2S), a channel word is the N bits that follow the first bit clock of its half-frame. Any later bits in that half-frame are ignored.
- R4: The word length N is set by `wlen_sel_i`: 2'b00 gives 16 bits, 2'b01 gives 20, 2'b10 gives 24 and 2'b11 gives 18.
- R5: With `lr_swap_i`=0, a frame-clock level of 1 marks the left channel. With `lr_swap_i`=1, a level of 0 marks the left channel. A frame is a left half-frame followed by a right half-frame.
- R6: An N-bit word is output in bits [23:24-N] of `left_o` or `right_o`, with zeros in the low 24-N bits.
- R7: In right-justified format, a frame of exactly 32 bit clocks is received as two 16-bit words, whatever `wlen_sel_i` is set to.
- R8: `valid_o` pulses for exactly one cycle per good frame. It is high in the cycle that follows the rising edge on which the frame-clock change ending the right half-frame is first sampled.
- R9: A half-frame is short when it has fewer than N bit clocks in right-justified format, or fewer than N+1 in I2S. A frame with a short half-frame pulses `short_o` instead of `valid_o`, and `left_o` and `right_o` keep their previous values.
- R10: `left_o` and `right_o` change only in cycles where `valid_o` is high.
- R11: After reset, the half-frame in progress at the first sampled frame-clock level is discarded, and no pair is output until a complete left half-frame and a complete right half-frame have been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio bit clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s_i | input | 1 | 0: right-justified, 1: I2S framing |
| wlen_sel_i | input | 2 | Word-length code (see R4) |
| lr_swap_i | input | 1 | Frame-clock polarity select (see R5) |
| lrclk_i | input | 1 | Frame (left/right) clock |
| sdata_i | input | 1 | Serial audio data, MSB first |
| left_o | output | 24 | Left sample, left-aligned, signed |
| right_o | output | 24 | Right sample, left-aligned, signed |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| short_o | output | 1 | One-cycle strobe for a frame rejected as short |

## Verification
Filler ones are driven into every bit slot outside the word, in both framings. A design that takes the wrong window, or shifts past it, then returns set low bits or a corrupted MSB. A 16+16 right-justified frame is sent at 24-bit and 20-bit settings. A design without the packed-frame rule would flag the frame as short or misplace the word. Short frames include a lopsided 12+20 frame that still totals 32 clocks, and an I2S frame that has exactly N bits but no spare leading slot. A design that counted badly would then update the outputs or miss `short_o`. Each group of frames starts after reset in the middle of a half-frame, so a receiver that accepts the partial half-frame emits a sample pair the scoreboard does not expect.

// File: rtl/pcm_serial_rx_pkg.sv
package pcm_serial_rx_pkg;

  localparam int SAMPLE_W = 24;

  // word-length code to bit count
  function automatic logic [4:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'b00:   wlen_bits = 5'd16;
      2'b01:   wlen_bits = 5'd20;
      2'b10:   wlen_bits = 5'd24;
      default: wlen_bits = 5'd18;
    endcase
  endfunction

endpackage

// File: rtl/pcm_lr_tracker.sv
module pcm_lr_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrclk_i,
  output logic             lr_edge,
  output logic             lr_prev,
  output logic             started,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] half_len
);

  logic             primed_q, primed_d;
  logic             lr_q, lr_d;
  logic             started_q, started_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign lr_edge  = primed_q && (lrclk_i != lr_q);
  assign lr_prev  = lr_q;
  assign started  = started_q;
  assign half_len = cnt_q;
  assign pos      = lr_edge ? '0 : cnt_q;

  always_comb begin
    primed_d  = 1'b1;
    lr_d      = lrclk_i;
    started_d = started_q | lr_edge;
    if (lr_edge)              cnt_d = CNT_W'(1);
    else if (cnt_q == '1)     cnt_d = cnt_q;
    else                      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      lr_q      <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      primed_q  <= primed_d;
      lr_q      <= lr_d;
      started_q <= started_d;
      cnt_q     <= cnt_d;
    end
  end

  // half-frame counter restarts at one bit after every frame-clock change
  assert_count_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lr_edge |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/pcm_bit_shifter.sv
module pcm_bit_shifter #(
  parameter int OUT_W = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata_i,
  input  logic             lr_edge,
  input  logic [CNT_W-1:0] pos,
  input  logic             fmt_i2s,
  input  logic [4:0]       wlen_n,
  output logic [OUT_W-1:0] word_q
);

  logic [OUT_W-1:0] word_d;
  logic             capture;
  logic [CNT_W-1:0] n_ext;

  assign n_ext = {{(CNT_W-5){1'b0}}, wlen_n};
  // right-justified keeps shifting (last bits win); I2S takes slots 1..N only
  assign capture = !fmt_i2s || ((pos != '0) && (pos <= n_ext));

  always_comb begin
    word_d = word_q;
    if (lr_edge)      word_d = capture ? {{(OUT_W-1){1'b0}}, sdata_i} : '0;
    else if (capture) word_d = {word_q[OUT_W-2:0], sdata_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

endmodule

// File: rtl/pcm_frame_assembler.sv
module pcm_frame_assembler
  import pcm_serial_rx_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lr_edge,
  input  logic             lr_prev,
  input  logic             started,
  input  logic [CNT_W-1:0] half_len,
  input  logic [OUT_W-1:0] word,
  input  logic             fmt_i2s,
  input  logic [1:0]       wlen_sel,
  input  logic             lr_swap,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             short_o
);

  localparam logic [CNT_W:0] PACKED_LEN = (CNT_W+1)'(32);

  logic             have_left_q, have_left_d;
  logic [OUT_W-1:0] left_raw_q, left_raw_d;
  logic [CNT_W-1:0] left_len_q, left_len_d;
  logic [OUT_W-1:0] left_q, left_d, right_q, right_d;
  logic             valid_q, valid_d, short_q, short_d;

  logic             done_left, done_right, packed_frame, frame_short;
  logic [4:0]       cfg_n, eff_n;
  logic [5:0]       need;
  logic [CNT_W-1:0] need_ext;
  logic [CNT_W:0]   frame_len;

  function automatic logic [OUT_W-1:0] align(input logic [OUT_W-1:0] raw,
                                             input logic [4:0] n);
    logic [5:0] shamt;
    shamt = 6'(OUT_W) - {1'b0, n};
    align = raw << shamt;
  endfunction

  assign cfg_n        = wlen_bits(wlen_sel);
  assign done_left    = lr_edge && started && (lr_prev ^ lr_swap);
  assign done_right   = lr_edge && started && !(lr_prev ^ lr_swap);
  assign frame_len    = {1'b0, left_len_q} + {1'b0, half_len};
  assign packed_frame = !fmt_i2s && (frame_len == PACKED_LEN);
  assign eff_n        = packed_frame ? 5'd16 : cfg_n;
  assign need         = fmt_i2s ? ({1'b0, cfg_n} + 6'd1) : {1'b0, eff_n};
  assign need_ext     = {{(CNT_W-6){1'b0}}, need};
  assign frame_short  = (left_len_q < need_ext) || (half_len < need_ext);

  always_comb begin
    have_left_d = have_left_q;
    left_raw_d  = left_raw_q;
    left_len_d  = left_len_q;
    left_d      = left_q;
    right_d     = right_q;
    valid_d     = 1'b0;
    short_d     = 1'b0;
    if (done_left) begin
      have_left_d = 1'b1;
      left_raw_d  = word;
      left_len_d  = half_len;
    end
    if (done_right) begin
      have_left_d = 1'b0;
      if (have_left_q) begin
        if (frame_short) begin
          short_d = 1'b1;
        end else begin
          valid_d = 1'b1;
          left_d  = align(left_raw_q, eff_n);
          right_d = align(word, eff_n);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_left_q <= 1'b0;
      left_raw_q  <= '0;
      left_len_q  <= '0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
      short_q     <= 1'b0;
    end else begin
      have_left_q <= have_left_d;
      left_raw_q  <= left_raw_d;
      left_len_q  <= left_len_d;
      left_q      <= left_d;
      right_q     <= right_d;
      valid_q     <= valid_d;
      short_q     <= short_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
  assign short_o = short_q;

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && short_o));

  assert_hold_on_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    short_o |-> ($stable(left_o) && $stable(right_o)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_serial_rx_pkg::*;
#(
  parameter int OUT_W = SAMPLE_W,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_i2s_i,
  input  logic [1:0]       wlen_sel_i,
  input  logic             lr_swap_i,
  input  logic             lrclk_i,
  input  logic             sdata_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             short_o
);

  logic             lr_edge, lr_prev, started;
  logic [CNT_W-1:0] pos, half_len;
  logic [OUT_W-1:0] word;

  pcm_lr_tracker #(.CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .lrclk_i  (lrclk_i),
    .lr_edge  (lr_edge),
    .lr_prev  (lr_prev),
    .started  (started),
    .pos      (pos),
    .half_len (half_len)
  );

  pcm_bit_shifter #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdata_i (sdata_i),
    .lr_edge (lr_edge),
    .pos     (pos),
    .fmt_i2s (fmt_i2s_i),
    .wlen_n  (wlen_bits(wlen_sel_i)),
    .word_q  (word)
  );

  pcm_frame_assembler #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .lr_edge  (lr_edge),
    .lr_prev  (lr_prev),
    .started  (started),
    .half_len (half_len),
    .word     (word),
    .fmt_i2s  (fmt_i2s_i),
    .wlen_sel (wlen_sel_i),
    .lr_swap  (lr_swap_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o),
    .short_o  (short_o)
  );

endmodule

// File: tb/pcm_serial_rx_test.sv
module pcm_serial_rx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_i2s = 1'b0;
  logic [1:0]  wlen_sel = 2'b10;
  logic        lr_swap = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o, short_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          shrt;
    logic [23:0] l;
    logic [23:0] r;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  logic [23:0] last_l = '0, last_r = '0;

  always #2 clk = ~clk;

  pcm_serial_rx uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_i2s_i  (fmt_i2s),
    .wlen_sel_i (wlen_sel),
    .lr_swap_i  (lr_swap),
    .lrclk_i    (lrclk),
    .sdata_i    (sdata),
    .left_o     (left_o),
    .right_o    (right_o),
    .valid_o    (valid_o),
    .short_o    (short_o)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] act,
                       input logic [47:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic int wbits(input logic [1:0] c);
    case (c)
      2'b00: return 16;   // R4
      2'b01: return 20;
      2'b10: return 24;
      default: return 18;
    endcase
  endfunction

  function automatic logic left_lvl();
    return lr_swap ? 1'b0 : 1'b1;   // R5
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (valid_o || short_o)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected output", {23'd0, valid_o, 23'd0, short_o}, 48'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(short_o == e.shrt && valid_o == !e.shrt, {e.tag, " strobe kind"},
              {47'd0, short_o}, {47'd0, e.shrt});
        check({left_o, right_o} == {e.l, e.r}, {e.tag, " sample pair"},
              {left_o, right_o}, {e.l, e.r});
      end
    end
  end

  task automatic bit_out(input logic lv, input logic d);
    @(negedge clk);
    lrclk = lv;
    sdata = d;
  endtask

  task automatic drive_half(input logic lv, input int len, input logic [23:0] w,
                            input int n);
    for (int p = 0; p < len; p++) begin
      logic d;
      if (fmt_i2s) begin
        d = (p >= 1 && p <= n) ? w[n-p] : 1'b1;            // R3
      end else begin
        d = (len - 1 - p < n) ? w[len-1-p] : 1'b1;         // R2
      end
      bit_out(lv, d);
    end
  endtask

  task automatic send_frame(input int ll, input int rl, input logic [23:0] lw,
                            input logic [23:0] rw, input string tag);
    int n, eff, need;
    exp_t e;
    n    = wbits(wlen_sel);
    eff  = (!fmt_i2s && ll + rl == 32) ? 16 : n;   // R7
    need = fmt_i2s ? n + 1 : eff;
    e.tag = tag;
    if (ll < need || rl < need) begin
      e.shrt = 1'b1; e.l = last_l; e.r = last_r;   // R9
    end else begin
      logic [23:0] m;
      m = (24'hFFFFFF >> (24 - eff));
      e.shrt = 1'b0;
      e.l = (lw & m) << (24 - eff);                // R6
      e.r = (rw & m) << (24 - eff);
      last_l = e.l; last_r = e.r;
    end
    exp_q.push_back(e);
    drive_half(left_lvl(), ll, lw, eff);
    drive_half(!left_lvl(), rl, rw, eff);
  endtask

  task automatic start_group(input bit i2s, input logic [1:0] wl, input bit swp,
                             input bit partial_left);
    @(negedge clk);
    rst_n = 1'b0;
    fmt_i2s = i2s; wlen_sel = wl; lr_swap = swp;
    lrclk = partial_left ? left_lvl() : !left_lvl();
    last_l = '0; last_r = '0;
    repeat (2) @(negedge clk);
    check(valid_o == 0 && short_o == 0 && left_o == 0 && right_o == 0,
          "R1 reset state", {left_o, right_o}, 48'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 0 && short_o == 0 && left_o == 0 && right_o == 0,
          "R1 after release", {left_o, right_o}, 48'd0);
    if (partial_left) begin
      // R11: partial left, then a complete right with no left before it
      drive_half(left_lvl(), 5, 24'h0, 0);
      drive_half(!left_lvl(), 24, 24'h5A5A5A, 24);
    end else begin
      drive_half(!left_lvl(), 3, 24'h0, 0);
    end
  endtask

  task automatic close_group(input string tag);
    drive_half(left_lvl(), 3, 24'h0, 0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {tag, " all frames emitted"}, 48'(exp_q.size()), 48'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 R4 R8: right-justified 24-bit in 32-slot halves
    start_group(1'b0, 2'b10, 1'b0, 1'b0);
    send_frame(32, 32, 24'h812345, 24'h7ABCDE, "R2");
    send_frame(32, 32, 24'h000001, 24'hFFFFFF, "R8");
    close_group("R8");

    // R4 R6: 16-bit in 20-slot halves
    start_group(1'b0, 2'b00, 1'b0, 1'b0);
    send_frame(20, 20, 24'h00BEEF, 24'h008001, "R6");
    close_group("R4");

    // R5: swapped polarity, 20-bit
    start_group(1'b0, 2'b01, 1'b1, 1'b0);
    send_frame(24, 24, 24'h0F1E2D, 24'h0A5A5A, "R5");
    send_frame(24, 24, 24'h080000, 24'h000003, "R5");
    close_group("R5");

    // R4: 18-bit code 11
    start_group(1'b0, 2'b11, 1'b0, 1'b0);
    send_frame(24, 24, 24'h02ABCD, 24'h01FFFF, "R4");
    close_group("R4");

    // R7: packed 32-clock frame at 24-bit and 20-bit settings
    start_group(1'b0, 2'b10, 1'b0, 1'b0);
    send_frame(16, 16, 24'h00C3A5, 24'h00123F, "R7");
    close_group("R7");
    start_group(1'b0, 2'b01, 1'b1, 1'b0);
    send_frame(16, 16, 24'h007FFF, 24'h008000, "R7");
    close_group("R7");

    // R3: I2S 24-bit and 16-bit, trailing filler ignored
    start_group(1'b1, 2'b10, 1'b0, 1'b0);
    send_frame(32, 32, 24'hA5C30F, 24'h3C5A69, "R3");
    close_group("R3");
    start_group(1'b1, 2'b00, 1'b1, 1'b0);
    send_frame(20, 20, 24'h00F00D, 24'h004321, "R3");
    send_frame(16, 16, 24'h001111, 24'h002222, "R9");   // no spare slot: short
    send_frame(17, 17, 24'h00ABCD, 24'h00DCBA, "R3");
    close_group("R3");

    // R9: short frames keep the last pair
    start_group(1'b0, 2'b10, 1'b0, 1'b0);
    send_frame(32, 32, 24'h654321, 24'h123456, "R9");
    send_frame(32, 20, 24'h111111, 24'h222222, "R9");
    send_frame(12, 20, 24'h333333, 24'h444444, "R9");
    send_frame(24, 24, 24'h7F0000, 24'h80FFFF, "R10");
    close_group("R9");

    // R11: start mid left half-frame
    start_group(1'b0, 2'b10, 1'b0, 1'b1);
    send_frame(32, 32, 24'h13579B, 24'h2468AC, "R11");
    close_group("R11");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule